// File: doc/BRIEF.md
# Call, Return and Stack Sequencer

This block is the program-flow engine of a small 8-bit processor with a 16-bit program counter and a 16-bit stack pointer. It receives an operation code and a 16-bit immediate from an upstream decoder. It then runs the stack and table traffic that operation needs through a byte-wide data-memory port, one access per cycle. When the operation ends it commits the new program counter, stack pointer, flag byte, AX pair, interrupt-enable bit and non-maskable-in-service bit.

The operations are:
- three kinds of call;
- a software break;
- three returns;
- pushes and pops of the flag byte and of AX;
- moves between SP, AX and an immediate;
- absolute, register-indirect, relative and conditional branches.

Instruction fetch and sequential PC advance belong to the fetch unit. Operations that do not branch leave the program counter alone.

The memory read data is combinational. It is valid in the same cycle as the request and is sampled at the clock edge that ends that cycle.

Top module: `flow_stack_seq`

## Requirements
- R1: After reset the outputs are pc=0000h, sp=FF00h (SP_INIT), psw=00h, ax=0000h, ie=1, nmis=1, busy=0, done=0 and mem_req=0.
- R2: An operation is accepted on a clock edge where start=1 and busy=0. It then performs exactly one memory access per busy cycle, and it is busy for max(N,1) cycles, where N is its access count. done is high for the one cycle that follows the last busy cycle, and registers change only at that edge. Operation codes are: 0 no-op, 1 CALL, 2 CALLF, 3 CALLT, 4 BRK, 5 RET, 6 RETI, 7 RETB, 8 PUSH_PSW, 9 PUSH_AX, 10 POP_PSW, 11 POP_AX, 12 MOV_SP_IMM, 13 MOV_SP_AX, 14 MOV_AX_SP, 15 BR_ABS, 16 BR_REL, 17 BC, 18 BNC, 19 BZ, 20 BNZ, 21 BR_AX. Codes 22 to 31 behave as the no-op.
- R3: CALL writes (pc+3) high byte to sp-1, then (pc+3) low byte to sp-2. It then sets pc=imm and sp=sp-2.
- R4: CALLF pushes pc+2 in the same order. It then sets pc to {5'b00001, imm[10:0]} and sp=sp-2.
- R5: CALLT pushes pc+1 in the same order. It then reads the new pc low byte from T = 0040h + 2*imm[4:0] and the high byte from T+1, and sets sp=sp-2.
- R6: BRK writes psw to sp-1, (pc+1) high byte to sp-2 and (pc+1) low byte to sp-3, in that order. It then reads the pc low byte from 003Eh and the high byte from 003Fh, sets sp=sp-3 and clears ie.
- R7: RET reads the pc low byte from sp and the high byte from sp+1, then sets sp=sp+2.
- R8: RETI and RETB read the pc as RET does, then read psw from sp+2 and set sp=sp+3. RETI also clears nmis; RETB leaves nmis and ie unchanged.
- R9: PUSH_PSW writes psw to sp-1 and sets sp=sp-1. PUSH_AX writes ax[15:8] to sp-1, then ax[7:0] to sp-2, and sets sp=sp-2. POP_PSW reads psw from sp and sets sp=sp+1. POP_AX reads ax[7:0] from sp and ax[15:8] from sp+1, and sets sp=sp+2. During these operations pc does not change.
- R10: MOV_SP_IMM sets sp=imm. MOV_SP_AX sets sp=ax. MOV_AX_SP sets ax=sp. BR_ABS sets pc=imm. BR_AX sets pc=ax, with ax[15:8] as the high byte. None of these makes a memory access.
- R11: BR_REL always branches. BC branches when psw[0] (CY) is 1, BNC when it is 0, BZ when psw[6] (Z) is 1 and BNZ when it is 0. A taken branch sets pc = pc+2+sign-extended imm[7:0]; a branch not taken sets pc=pc+2.
- R12: All SP, PC and access-address arithmetic wraps modulo 2^16.
- R13: A start pulse while busy=1 is ignored. The running operation's accesses and results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| op_in | input | 5 | Operation code (see R2) |
| imm_in | input | 16 | Immediate field of the operation |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| psw | output | 8 | Flag byte, CY at bit 0, Z at bit 6 |
| ax | output | 16 | Register pair, A high byte, X low byte |
| ie | output | 1 | Interrupt enable |
| nmis | output | 1 | Non-maskable interrupt in service |

## Verification
A wrong step counter or access table shows directly on the memory port. It appears as a wrong address, direction or byte in the same cycle, or as an access count that disagrees with the busy length. A wrong read-buffer slot or commit decode stays hidden until the done cycle. There it appears as a wrong pc, sp, psw or ax. It also spreads to every later stack address, so the next push or return exposes it as well. A stray change of ie or nmis shows as an edge that is not aligned with done.

// File: rtl/fss_pkg.sv
package fss_pkg;
  localparam int AW     = 16;
  localparam int DW     = 8;
  localparam int OPW    = 5;
  localparam int STW    = 3;
  localparam int MAXACC = 5;
  localparam int CY_BIT = 0;
  localparam int Z_BIT  = 6;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 5'd0, OP_CALL = 5'd1, OP_CALLF = 5'd2, OP_CALLT = 5'd3,
    OP_BRK = 5'd4, OP_RET = 5'd5, OP_RETI = 5'd6, OP_RETB = 5'd7,
    OP_PUSH_PSW = 5'd8, OP_PUSH_AX = 5'd9, OP_POP_PSW = 5'd10,
    OP_POP_AX = 5'd11, OP_MOV_SP_IMM = 5'd12, OP_MOV_SP_AX = 5'd13,
    OP_MOV_AX_SP = 5'd14, OP_BR_ABS = 5'd15, OP_BR_REL = 5'd16,
    OP_BC = 5'd17, OP_BNC = 5'd18, OP_BZ = 5'd19, OP_BNZ = 5'd20,
    OP_BR_AX = 5'd21
  } op_e;

  // number of memory byte accesses an operation performs
  function automatic logic [STW-1:0] acc_count(op_e op);
    case (op)
      OP_CALL, OP_CALLF, OP_RET, OP_PUSH_AX, OP_POP_AX: return STW'(2);
      OP_CALLT:                                          return STW'(4);
      OP_BRK:                                            return STW'(5);
      OP_RETI, OP_RETB:                                  return STW'(3);
      OP_PUSH_PSW, OP_POP_PSW:                           return STW'(1);
      default:                                           return STW'(0);
    endcase
  endfunction

  // return address pushed by the call forms and the break
  function automatic logic [AW-1:0] ret_addr(op_e op, logic [AW-1:0] pc);
    case (op)
      OP_CALL:  return pc + AW'(3);
      OP_CALLF: return pc + AW'(2);
      default:  return pc + AW'(1);
    endcase
  endfunction

  function automatic logic [AW-1:0] page_target(logic [10:0] low);
    return {5'b00001, low};
  endfunction

  function automatic logic [AW-1:0] rel_target(logic [AW-1:0] pc, logic [DW-1:0] d);
    return pc + AW'(2) + {{(AW-DW){d[DW-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] tbl_addr(logic [DW-1:0] base, logic [4:0] idx);
    return {{(AW-DW){1'b0}}, base + {2'b00, idx, 1'b0}};
  endfunction

  function automatic logic br_taken(op_e op, logic [DW-1:0] flags);
    case (op)
      OP_BC:   return flags[CY_BIT];
      OP_BNC:  return !flags[CY_BIT];
      OP_BZ:   return flags[Z_BIT];
      OP_BNZ:  return !flags[Z_BIT];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/fss_ctrl.sv
module fss_ctrl
  import fss_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op_in,
  input  logic [AW-1:0]  imm_in,
  output logic           busy,
  output logic [STW-1:0] step,
  output op_e            op_q,
  output logic [AW-1:0]  imm_q,
  output logic           commit,
  output logic           done
);
  logic [STW-1:0] cnt;
  logic           last_step;

  assign cnt       = acc_count(op_q);
  assign last_step = (cnt == '0) ? 1'b1 : (step == cnt - STW'(1));
  assign commit    = busy && last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      step  <= '0;
      op_q  <= OP_NOP;
      imm_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= commit;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          step  <= '0;
          op_q  <= op_e'(op_in);
          imm_q <= imm_in;
        end
      end else if (last_step) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + STW'(1);
      end
    end
  end
endmodule

// File: rtl/fss_access.sv
module fss_access
  import fss_pkg::*;
#(
  parameter logic [DW-1:0] TBL_BASE = 8'h40,
  parameter logic [AW-1:0] BRK_VEC  = 16'h003E
) (
  input  op_e            op,
  input  logic [STW-1:0] step,
  input  logic [AW-1:0]  sp,
  input  logic [AW-1:0]  pc,
  input  logic [DW-1:0]  psw,
  input  logic [AW-1:0]  ax,
  input  logic [4:0]     tbl_idx,
  output logic           acc_vld,
  output logic           acc_we,
  output logic [AW-1:0]  acc_addr,
  output logic [DW-1:0]  acc_wdata
);
  logic [AW-1:0] ret;
  logic [AW-1:0] tbl;

  assign ret = ret_addr(op, pc);
  assign tbl = tbl_addr(TBL_BASE, tbl_idx);

  always_comb begin
    acc_vld   = step < acc_count(op);
    acc_we    = 1'b0;
    acc_addr  = sp;
    acc_wdata = '0;
    case (op)
      OP_CALL, OP_CALLF, OP_CALLT: begin
        case (step)
          3'd0: begin acc_we = 1'b1; acc_addr = sp - AW'(1); acc_wdata = ret[AW-1:DW]; end
          3'd1: begin acc_we = 1'b1; acc_addr = sp - AW'(2); acc_wdata = ret[DW-1:0]; end
          3'd2: acc_addr = tbl;
          3'd3: acc_addr = tbl + AW'(1);
          default: ;
        endcase
      end
      OP_BRK: begin
        case (step)
          3'd0: begin acc_we = 1'b1; acc_addr = sp - AW'(1); acc_wdata = psw; end
          3'd1: begin acc_we = 1'b1; acc_addr = sp - AW'(2); acc_wdata = ret[AW-1:DW]; end
          3'd2: begin acc_we = 1'b1; acc_addr = sp - AW'(3); acc_wdata = ret[DW-1:0]; end
          3'd3: acc_addr = BRK_VEC;
          3'd4: acc_addr = BRK_VEC + AW'(1);
          default: ;
        endcase
      end
      OP_RET, OP_RETI, OP_RETB, OP_POP_PSW, OP_POP_AX:
        acc_addr = sp + AW'(step);
      OP_PUSH_PSW: begin
        acc_we = 1'b1; acc_addr = sp - AW'(1); acc_wdata = psw;
      end
      OP_PUSH_AX: begin
        acc_we   = 1'b1;
        acc_addr = (step == '0) ? sp - AW'(1) : sp - AW'(2);
        acc_wdata = (step == '0) ? ax[AW-1:DW] : ax[DW-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fss_regs.sv
module fss_regs
  import fss_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT   = 16'hFF00,
  parameter logic          IE_INIT   = 1'b1,
  parameter logic          NMIS_INIT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic           rd_en,
  input  logic [STW-1:0] step,
  input  op_e            op_q,
  input  logic [AW-1:0]  imm_q,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  sp,
  output logic [DW-1:0]  psw,
  output logic [AW-1:0]  ax,
  output logic           ie,
  output logic           nmis
);
  // byte read at step k: live data in its own cycle, held copy afterwards
  logic [MAXACC-1:0][DW-1:0] rb;

  for (genvar k = 0; k < MAXACC; k++) begin : g_buf
    logic [DW-1:0] held;
    logic          hit;
    assign hit = rd_en && (step == STW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   held <= '0;
      else if (hit) held <= mem_rdata;
    end
    assign rb[k] = hit ? mem_rdata : held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      sp   <= SP_INIT;
      psw  <= '0;
      ax   <= '0;
      ie   <= IE_INIT;
      nmis <= NMIS_INIT;
    end else if (commit) begin
      case (op_q)
        OP_CALL:  begin pc <= imm_q;                     sp <= sp - AW'(2); end
        OP_CALLF: begin pc <= page_target(imm_q[10:0]);  sp <= sp - AW'(2); end
        OP_CALLT: begin pc <= {rb[3], rb[2]};            sp <= sp - AW'(2); end
        OP_BRK:   begin pc <= {rb[4], rb[3]}; sp <= sp - AW'(3); ie <= 1'b0; end
        OP_RET:   begin pc <= {rb[1], rb[0]};            sp <= sp + AW'(2); end
        OP_RETI, OP_RETB: begin
          pc  <= {rb[1], rb[0]};
          psw <= rb[2];
          sp  <= sp + AW'(3);
          if (op_q == OP_RETI) nmis <= 1'b0;
        end
        OP_PUSH_PSW:   sp <= sp - AW'(1);
        OP_PUSH_AX:    sp <= sp - AW'(2);
        OP_POP_PSW:    begin psw <= rb[0];          sp <= sp + AW'(1); end
        OP_POP_AX:     begin ax  <= {rb[1], rb[0]}; sp <= sp + AW'(2); end
        OP_MOV_SP_IMM: sp <= imm_q;
        OP_MOV_SP_AX:  sp <= ax;
        OP_MOV_AX_SP:  ax <= sp;
        OP_BR_ABS:     pc <= imm_q;
        OP_BR_AX:      pc <= ax;
        OP_BR_REL, OP_BC, OP_BNC, OP_BZ, OP_BNZ:
          pc <= br_taken(op_q, psw) ? rel_target(pc, imm_q[DW-1:0]) : pc + AW'(2);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/flow_stack_seq.sv
module flow_stack_seq
  import fss_pkg::*;
#(
  parameter logic [AW-1:0] SP_INIT   = 16'hFF00,
  parameter logic [DW-1:0] TBL_BASE  = 8'h40,
  parameter logic [AW-1:0] BRK_VEC   = 16'h003E,
  parameter logic          IE_INIT   = 1'b1,
  parameter logic          NMIS_INIT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [4:0]    op_in,
  input  logic [15:0]   imm_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [15:0]   pc,
  output logic [15:0]   sp,
  output logic [7:0]    psw,
  output logic [15:0]   ax,
  output logic          ie,
  output logic          nmis
);
  logic [STW-1:0] step;
  op_e            op_q;
  logic [AW-1:0]  imm_q;
  logic           commit;
  logic           acc_vld;
  logic           acc_we;
  logic [AW-1:0]  acc_addr;
  logic [DW-1:0]  acc_wdata;
  logic           rd_en;

  fss_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op_in(op_in), .imm_in(imm_in),
    .busy(busy), .step(step), .op_q(op_q), .imm_q(imm_q),
    .commit(commit), .done(done)
  );

  fss_access #(.TBL_BASE(TBL_BASE), .BRK_VEC(BRK_VEC)) u_access (
    .op(op_q), .step(step), .sp(sp), .pc(pc), .psw(psw), .ax(ax),
    .tbl_idx(imm_q[4:0]), .acc_vld(acc_vld), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata)
  );

  assign mem_req   = busy && acc_vld;
  assign mem_we    = mem_req && acc_we;
  assign rd_en     = mem_req && !acc_we;
  assign mem_addr  = acc_addr;
  assign mem_wdata = acc_wdata;

  fss_regs #(.SP_INIT(SP_INIT), .IE_INIT(IE_INIT), .NMIS_INIT(NMIS_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .rd_en(rd_en), .step(step),
    .op_q(op_q), .imm_q(imm_q), .mem_rdata(mem_rdata),
    .pc(pc), .sp(sp), .psw(psw), .ax(ax), .ie(ie), .nmis(nmis)
  );
endmodule

// File: rtl/fss_chk.sv
module fss_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic        mem_we,
  input logic [15:0] pc,
  input logic [15:0] sp,
  input logic        ie,
  input logic        nmis
);
  // R2: memory traffic only inside an operation
  assert_req_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  // R2: a write is always a request
  assert_we_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  // R2: done lasts one cycle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: done follows a busy cycle and the block is idle while it is high
  assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R2: pc only moves at the end of an operation
  assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(pc));
  // R13: sp stays put while an operation is in flight
  assert_sp_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sp));
  // R6: ie falls only on an operation end
  assert_ie_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> done);
  // R8: nmis falls only on an operation end
  assert_nmis_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmis) |-> done);
endmodule

bind flow_stack_seq fss_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .pc(pc), .sp(sp), .ie(ie), .nmis(nmis)
);

// File: tb/flow_stack_seq_tb_top.sv
`timescale 1ns/1ps
module flow_stack_seq_tb_top;
  localparam logic [4:0] NOP=0, CALL=1, CALLF=2, CALLT=3, BRK=4, RET=5, RETI=6,
    RETB=7, PUSHP=8, PUSHA=9, POPP=10, POPA=11, MSPI=12, MSPA=13, MASP=14,
    BRA=15, BRR=16, BC=17, BNC=18, BZ=19, BNZ=20, BRX=21;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] op_in = '0;
  logic [15:0] imm_in = '0;
  logic mem_req, mem_we, busy, done, ie, nmis;
  logic [15:0] mem_addr, pc, sp, ax;
  logic [7:0] mem_wdata, psw;
  logic [7:0] mem_rdata = '0;

  int total = 0, fails = 0;
  bit [7:0] mem [bit [15:0]];
  logic [15:0] obs_a[$], exp_a[$];
  logic [7:0]  obs_d[$], exp_d[$];
  logic [15:0] m_pc = 16'h0000, m_sp = 16'hFF00, m_ax = 16'h0000;
  logic [7:0]  m_psw = 8'h00;
  logic        m_ie = 1'b1, m_nmis = 1'b1;

  always #2.5 clk = ~clk;

  flow_stack_seq dut_i (.*);

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // read as the spec orders it: writes of this operation come first
  function automatic logic [7:0] rdm(input logic [15:0] a);
    for (int i = exp_a.size() - 1; i >= 0; i--) if (exp_a[i] == a) return exp_d[i];
    return rd(a);
  endfunction

  always @(negedge clk) mem_rdata <= rd(mem_addr);
  always @(posedge clk) if (mem_req && mem_we) begin
    mem[mem_addr] = mem_wdata;
    obs_a.push_back(mem_addr);
    obs_d.push_back(mem_wdata);
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      CALL: return "R3";  CALLF: return "R4"; CALLT: return "R5"; BRK: return "R6";
      RET: return "R7";   RETI, RETB: return "R8";
      PUSHP, PUSHA, POPP, POPA: return "R9";
      MSPI, MSPA, MASP, BRA, BRX: return "R10";
      BRR, BC, BNC, BZ, BNZ: return "R11";
      default: return "R2";
    endcase
  endfunction

  function automatic logic taken(input logic [4:0] op, input logic [7:0] f);
    if (op == BC)  return f[0];
    if (op == BNC) return !f[0];
    if (op == BZ)  return f[6];
    if (op == BNZ) return !f[6];
    return 1'b1;
  endfunction

  task automatic push_exp(input logic [15:0] a, input logic [7:0] d);
    exp_a.push_back(a); exp_d.push_back(d);
  endtask

  task automatic run(input logic [4:0] op, input logic [15:0] imm, input bit poke,
                     input string tagov);
    logic [15:0] r, t, npc, nsp, nax;
    logic [7:0] npsw;
    logic nie, nnm;
    int n, cyc, acc, it;
    string tg;
    tg = (tagov != "") ? tagov : tag_of(op);
    npc = m_pc; nsp = m_sp; nax = m_ax; npsw = m_psw; nie = m_ie; nnm = m_nmis; n = 0;
    exp_a.delete(); exp_d.delete();
    case (op)
      CALL, CALLF, CALLT: begin
        r = m_pc + ((op == CALL) ? 16'd3 : (op == CALLF) ? 16'd2 : 16'd1);
        push_exp(m_sp - 16'd1, r[15:8]); push_exp(m_sp - 16'd2, r[7:0]);
        nsp = m_sp - 16'd2; n = 2;
        if (op == CALL)  npc = imm;
        if (op == CALLF) npc = 16'h0800 | (imm & 16'h07FF);
        if (op == CALLT) begin
          t = 16'h0040 + 16'(imm[4:0]) * 16'd2;
          npc = {rdm(t + 16'd1), rdm(t)}; n = 4;
        end
      end
      BRK: begin
        r = m_pc + 16'd1;
        push_exp(m_sp - 16'd1, m_psw); push_exp(m_sp - 16'd2, r[15:8]);
        push_exp(m_sp - 16'd3, r[7:0]);
        npc = {rdm(16'h003F), rdm(16'h003E)}; nsp = m_sp - 16'd3; nie = 1'b0; n = 5;
      end
      RET, RETI, RETB: begin
        npc = {rdm(m_sp + 16'd1), rdm(m_sp)};
        if (op == RET) begin nsp = m_sp + 16'd2; n = 2; end
        else begin
          npsw = rdm(m_sp + 16'd2); nsp = m_sp + 16'd3; n = 3;
          if (op == RETI) nnm = 1'b0;
        end
      end
      PUSHP: begin push_exp(m_sp - 16'd1, m_psw); nsp = m_sp - 16'd1; n = 1; end
      PUSHA: begin
        push_exp(m_sp - 16'd1, m_ax[15:8]); push_exp(m_sp - 16'd2, m_ax[7:0]);
        nsp = m_sp - 16'd2; n = 2;
      end
      POPP: begin npsw = rdm(m_sp); nsp = m_sp + 16'd1; n = 1; end
      POPA: begin nax = {rdm(m_sp + 16'd1), rdm(m_sp)}; nsp = m_sp + 16'd2; n = 2; end
      MSPI: nsp = imm;
      MSPA: nsp = m_ax;
      MASP: nax = m_sp;
      BRA:  npc = imm;
      BRX:  npc = m_ax;
      BRR, BC, BNC, BZ, BNZ:
        npc = taken(op, m_psw) ? m_pc + 16'd2 + {{8{imm[7]}}, imm[7:0]} : m_pc + 16'd2;
      default: ;
    endcase

    obs_a.delete(); obs_d.delete();
    start = 1'b1; op_in = op; imm_in = imm;
    cyc = 0; acc = 0; it = 0;
    forever begin
      @(negedge clk);
      it++;
      if (it == 1 && poke) begin start = 1'b1; op_in = MSPI; imm_in = ~imm; end
      else start = 1'b0;
      if (busy) cyc++;
      if (mem_req) acc++;
      if (done) break;
      if (it > 40) begin chk(tg, "done timeout", 0, 1); break; end
    end
    chk("R2", "busy cycles", cyc, (n == 0) ? 1 : n);
    chk(tg, "access count", acc, n);
    chk(tg, "write count", obs_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < obs_a.size(); i++) begin
      chk(tg, "write addr", obs_a[i], exp_a[i]);
      chk(tg, "write data", obs_d[i], exp_d[i]);
    end
    chk(tg, "pc", pc, npc);   chk(tg, "sp", sp, nsp);
    chk(tg, "psw", psw, npsw); chk(tg, "ax", ax, nax);
    chk(tg, "ie", ie, nie);   chk(tg, "nmis", nmis, nnm);
    m_pc = npc; m_sp = nsp; m_ax = nax; m_psw = npsw; m_ie = nie; m_nmis = nnm;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pc", pc, 16'h0000);  chk("R1", "sp", sp, 16'hFF00);
    chk("R1", "psw", psw, 8'h00);   chk("R1", "ax", ax, 16'h0000);
    chk("R1", "ie", ie, 1'b1);      chk("R1", "nmis", nmis, 1'b1);
    chk("R1", "busy", busy, 1'b0);  chk("R1", "done", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mem_req idle", mem_req, 1'b0);

    // directed: flags, conditional branches, both polarities (R11)
    run(MSPI, 16'hC000, 0, "");
    mem[16'hC000] = 8'h41;
    run(POPP, 16'h0000, 0, "");
    run(BC, 16'h00F0, 0, ""); run(BNC, 16'h0010, 0, "");
    run(BZ, 16'h0022, 0, ""); run(BNZ, 16'h0033, 0, "");
    mem[16'hC001] = 8'h00;
    run(MSPI, 16'hC001, 0, ""); run(POPP, 16'h0, 0, "");
    run(BC, 16'h0005, 0, ""); run(BNC, 16'h0085, 0, "");
    run(BZ, 16'h0005, 0, ""); run(BNZ, 16'h00FE, 0, "");
    // calls, break and returns (R3..R9)
    mem[16'hC003] = 8'h34; mem[16'hC004] = 8'h12;
    run(POPA, 16'h0, 0, ""); run(PUSHA, 16'h0, 0, ""); run(PUSHP, 16'h0, 0, "");
    run(CALL, 16'h1234, 0, ""); run(RET, 16'h0, 0, "");
    run(CALLF, 16'hFFFF, 0, ""); run(CALLF, 16'h0000, 0, "");
    mem[16'h007E] = 8'hCD; mem[16'h007F] = 8'hAB;
    run(CALLT, 16'h001F, 0, ""); run(CALLT, 16'hFFE0, 0, "");
    mem[16'h003E] = 8'h78; mem[16'h003F] = 8'h56;
    run(BRK, 16'h0, 0, ""); run(RETB, 16'h0, 0, "");
    run(BRK, 16'h0, 0, ""); run(RETI, 16'h0, 0, "");
    run(MSPA, 16'h0, 0, ""); run(MASP, 16'h0, 0, ""); run(BRX, 16'h0, 0, "");
    run(NOP, 16'hFFFF, 0, ""); run(5'd31, 16'h1111, 0, "R2");
    // R12 wrap-around of stack and branch arithmetic
    run(MSPI, 16'h0001, 0, "R12"); run(PUSHA, 16'h0, 0, "R12");
    run(MSPI, 16'hFFFF, 0, "R12"); run(POPA, 16'h0, 0, "R12");
    run(BRA, 16'hFFFE, 0, "R12"); run(BRR, 16'h0005, 0, "R12");
    run(MSPI, 16'h0002, 0, "R12"); run(BRK, 16'h0, 0, "R12");
    // R13 a start while busy is ignored
    run(MSPI, 16'hB000, 0, "");
    run(CALL, 16'h4321, 1, "R13"); run(PUSHP, 16'h0, 1, "R13");
    run(BRA, 16'h2000, 1, "R13"); run(RETI, 16'h0, 1, "R13");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      logic [15:0] imm;
      if (i % 25 == 0) run(MSPI, 16'h8000 | 16'($urandom_range(0, 16'h3FFF)), 0, "");
      op  = 5'($urandom_range(0, 21));
      imm = 16'($urandom);
      for (int k = 0; k < 3; k++) mem[m_sp + 16'(k)] = 8'($urandom);
      run(op, imm, ($urandom_range(0, 7) == 0), "");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule